// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block turns signed parallel audio samples into the three-wire serial stream that a PCM audio DAC expects. The three wires are a bit clock, a data line and an active-low latch strobe. A sample enters through a valid/ready handshake and is copied into an internal shift register. The block then sends the word MSB first, one bit per bit-clock period. The receiver samples data on each rising bit-clock edge. After the final bit, the block drives the latch strobe low once, so the DAC moves the assembled word into its parallel register.

All serial timing comes from the system clock. Every bit-clock phase, the delay from the last rising edge to the latch strobe, the strobe width and the strobe recovery time is a whole count of system clocks. Each count is derived at elaboration from the system-clock period and rounded up, so every minimum interval is met. A parameter sets the word length to 16 or 18 bits, and that choice also sets the minimum bit-clock period.

Back-pressure rules: `smp_ready` is high only while the block is idle. A sample is taken on the rising system-clock edge where `smp_valid` and `smp_ready` are both high. While a word is in flight, `smp_ready` stays low, `smp_valid` is ignored, and `smp_data` may change freely. A source may hold `smp_valid` high across a transfer; its next sample is taken in the first idle cycle.

Top module: `serial_dac_tx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the outputs are: `smp_ready`=1, `dac_bclk`=0, `dac_latch_n`=1, `word_done`=0 and `dac_sdata`=0.
- R2: `smp_ready` is high only in the idle state. A sample is accepted only when `smp_valid` and `smp_ready` are both high, and `smp_ready` is low in the cycle after acceptance. Changing `smp_data` after acceptance does not alter the word that is sent.
- R3: Each accepted word produces exactly WORD_BITS rising bit-clock edges. The values of `dac_sdata` at those edges, MSB first, rebuild the two's complement sample bit for bit.
- R4: Each bit-clock high phase lasts HIGH_CYC system clocks, and each low phase between bits lasts LOW_CYC system clocks. Both counts equal ceil(max(30 ns, Tmin/2) / Tsys), where Tmin is 74.1 ns for 18-bit words and 80 ns for 16-bit words.
- R5: `dac_sdata` changes only on the cycle the bit clock falls, or while the bit clock is low, and it is stable across every rising edge. Setup time is therefore at least one low phase (≥30 ns), and hold time is at least one high phase (≥15 ns).
- R6: `dac_latch_n` falls only after all WORD_BITS rising edges of the word, with the bit clock low, and at least ceil(40 ns / Tsys) system clocks after the last rising edge. The latch strobe and the bit clock are never active together.
- R7: The latch strobe stays low for exactly ceil(40 ns / Tsys) system clocks.
- R8: Between two latch strobes, `dac_latch_n` stays high for at least ceil(40 ns / Tsys) system clocks, including back-to-back words.
- R9: `word_done` pulses for one system clock, in the cycle `dac_latch_n` returns high, once per word and at no other time.
- R10: When no word is in flight, the bit clock is low, the latch strobe is high, and `dac_sdata` holds the LSB of the last word sent.
- R11: A `smp_valid` held high while a word is in flight starts no extra word. The block sends only the samples that were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block idle; sample can be taken |
| smp_data | input | WORD_BITS | Two's complement sample |
| dac_bclk | output | 1 | Serial bit clock; idles low |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_latch_n | output | 1 | Active-low latch strobe; idles high |
| word_done | output | 1 | One-cycle pulse when the latch strobe ends |

## Verification
A monitor rebuilds every word from the data line at the rising bit-clock edges and measures each phase and strobe width in system clocks. Samples are chosen to separate distinct faults:
- Alternating bit patterns expose a shifted or dropped bit.
- The most negative, most positive, all-ones and zero words expose sign and end-of-word faults, including an LSB-first order.
- Sending samples back to back stresses the strobe recovery time.
- Changing the input just after acceptance, and holding valid high during a transfer, shows whether the block captures a word it should not have taken.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH,
    ST_RECOVER
  } tx_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacser_phase_cnt.sv
module dacser_phase_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R4: a running phase count steps down by one each cycle
  a_r4_count_steps: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dacser_shreg.sv
module dacser_shreg #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);

  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= din;
    end else if (shift) begin
      word_q <= {word_q[W-2:0], 1'b0};
    end
  end

  assign msb = word_q[W-1];

  // R2: a new sample is never captured in the same cycle a bit is advanced
  a_r2_load_shift_apart: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

endmodule

// File: rtl/dacser_ctrl.sv
module dacser_ctrl
  import dacser_pkg::*;
#(
  parameter int unsigned W          = 18,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned LOW_CYC    = 5,
  parameter int unsigned HIGH_CYC   = 5,
  parameter int unsigned GAP_CYC    = 1,
  parameter int unsigned STROBE_CYC = 5,
  parameter int unsigned REC_CYC    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             tmr_exp,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sr_load,
  output logic             sr_shift,
  output logic             bclk,
  output logic             latch_n,
  output logic             done
);

  localparam int unsigned BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  tx_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic             bclk_q, latch_n_q, done_q;
  logic             last_bit;

  assign last_bit = (bit_q == LAST_BIT);
  assign in_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          sr_load  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LOW_CYC - 1);
          state_d  = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HIGH_CYC - 1);
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (last_bit) begin
            tmr_val = CNT_W'(GAP_CYC - 1);
            state_d = ST_GAP;
          end else begin
            sr_shift = 1'b1;
            tmr_val  = CNT_W'(LOW_CYC - 1);
            state_d  = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(STROBE_CYC - 1);
          state_d  = ST_LATCH;
        end
      end
      ST_LATCH: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(REC_CYC - 1);
          state_d  = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      bclk_q    <= 1'b0;
      latch_n_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bclk_q    <= (state_d == ST_HIGH);
      latch_n_q <= (state_d != ST_LATCH);
      done_q    <= (state_q == ST_LATCH) && (state_d == ST_RECOVER);
      if (state_q == ST_IDLE) begin
        bit_q <= '0;
      end else if (sr_shift) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign bclk    = bclk_q;
  assign latch_n = latch_n_q;
  assign done    = done_q;

  // R6: the strobe falls only once the last bit has been clocked
  a_r6_strobe_after_last: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_n_q) |-> (bit_q == LAST_BIT));

  // R9: completion pulse coincides with the strobe returning high
  a_r9_done_on_release: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (latch_n_q && !$past(latch_n_q)));

  // R2: ready is offered only with both serial lines at rest
  a_r2_ready_at_rest: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!bclk_q && latch_n_q));

  // R3: the bit index never passes the word length
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (rst)
    bit_q <= LAST_BIT);

endmodule

// File: rtl/serial_dac_tx.sv
module serial_dac_tx
  import dacser_pkg::*;
#(
  parameter int unsigned WORD_BITS  = 18,
  parameter int unsigned SYS_CLK_PS = 8000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [WORD_BITS-1:0] smp_data,
  output logic                 dac_bclk,
  output logic                 dac_sdata,
  output logic                 dac_latch_n,
  output logic                 word_done
);

  localparam int unsigned MIN_PERIOD_PS = (WORD_BITS == 18) ? 74100 : 80000;
  localparam int unsigned PHASE_PS      = max_u(30000, ceil_div(MIN_PERIOD_PS, 2));
  localparam int unsigned LOW_CYC       = max_u(ceil_div(PHASE_PS, SYS_CLK_PS),
                                                ceil_div(30000, SYS_CLK_PS));
  localparam int unsigned HIGH_CYC      = max_u(ceil_div(PHASE_PS, SYS_CLK_PS),
                                                ceil_div(15000, SYS_CLK_PS));
  localparam int unsigned STROBE_CYC    = max_u(1, ceil_div(40000, SYS_CLK_PS));
  localparam int unsigned LEAD_CYC      = ceil_div(40000, SYS_CLK_PS);
  localparam int unsigned GAP_CYC       = (LEAD_CYC > HIGH_CYC + 1) ? (LEAD_CYC - HIGH_CYC) : 1;
  localparam int unsigned REC_CYC       = max_u(1, ceil_div(40000, SYS_CLK_PS));
  localparam int unsigned MAX_CYC       = max_u(max_u(LOW_CYC, HIGH_CYC),
                                                max_u(max_u(STROBE_CYC, GAP_CYC), REC_CYC));
  localparam int unsigned CNT_W         = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sr_load, sr_shift;

  dacser_phase_cnt #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  dacser_shreg #(.W(WORD_BITS)) u_shreg (
    .clk   (clk),
    .rst   (rst),
    .load  (sr_load),
    .shift (sr_shift),
    .din   (smp_data),
    .msb   (dac_sdata)
  );

  dacser_ctrl #(
    .W          (WORD_BITS),
    .CNT_W      (CNT_W),
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .GAP_CYC    (GAP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .REC_CYC    (REC_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .in_ready (smp_ready),
    .tmr_exp  (tmr_exp),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .sr_load  (sr_load),
    .sr_shift (sr_shift),
    .bclk     (dac_bclk),
    .latch_n  (dac_latch_n),
    .done     (word_done)
  );

  // R5: data holds steady for the whole high phase of the bit clock
  a_r5_data_steady_high: assert property (@(posedge clk) disable iff (rst)
    (dac_bclk && $past(dac_bclk)) |-> $stable(dac_sdata));

  // R6: strobe and bit clock are never active together
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(dac_bclk && !dac_latch_n));

endmodule

// File: tb/serial_dac_tx_tb_top.sv
`timescale 1ns/1ps
module serial_dac_tx_tb_top;

  localparam int WB      = 18;
  localparam int TSYS_PS = 8000;
  localparam int TMIN_PS = (WB == 18) ? 74100 : 80000;
  localparam int PH_PS   = (30000 > (TMIN_PS + 1) / 2) ? 30000 : (TMIN_PS + 1) / 2;
  localparam int EXP_PH  = (PH_PS + TSYS_PS - 1) / TSYS_PS;
  localparam int EXP_40  = (40000 + TSYS_PS - 1) / TSYS_PS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [WB-1:0] smp_data = '0;
  logic          dac_bclk, dac_sdata, dac_latch_n, word_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [WB-1:0] exp_q [0:63];
  int wr_i = 0, rd_i = 0, done_cnt = 0;

  logic          p_bclk, p_le, p_sd;
  int            run_len, bit_cnt, rise_age, le_hi, le_lo;
  logic [WB-1:0] acc;

  always #4 clk = ~clk;

  serial_dac_tx #(.WORD_BITS(WB), .SYS_CLK_PS(TSYS_PS)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .smp_data    (smp_data),
    .dac_bclk    (dac_bclk),
    .dac_sdata   (dac_sdata),
    .dac_latch_n (dac_latch_n),
    .word_done   (word_done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: rebuilds words and measures phases, sampled mid-cycle
  always @(negedge clk) begin
    if (rst) begin
      p_bclk = 1'b0; p_le = 1'b1; p_sd = 1'b0;
      run_len = 0; bit_cnt = 0; rise_age = 1000; le_hi = 1000; le_lo = 0; acc = '0;
    end else begin
      if (dac_bclk && !p_bclk) begin
        if (bit_cnt > 0) check(run_len == EXP_PH, "R4 low phase", run_len, EXP_PH);
        check(dac_sdata == p_sd, "R5 data at rise", dac_sdata, p_sd);
        acc = {acc[WB-2:0], dac_sdata};
        bit_cnt++;
        rise_age = 0;
        run_len = 1;
        if (bit_cnt > WB) check(1'b0, "R3 edge count", bit_cnt, WB);
      end else begin
        rise_age++;
        if (!dac_bclk && p_bclk) begin
          check(run_len == EXP_PH, "R4 high phase", run_len, EXP_PH);
          run_len = 1;
        end else begin
          run_len++;
        end
      end
      if (p_bclk && dac_bclk && dac_sdata != p_sd)
        check(1'b0, "R5 data moved while high", dac_sdata, p_sd);
      if (!dac_latch_n && p_le) begin
        check(bit_cnt == WB, "R6 edges before strobe", bit_cnt, WB);
        check(rise_age >= EXP_40, "R6 lead time", rise_age, EXP_40);
        check(le_hi >= EXP_40, "R8 strobe recovery", le_hi, EXP_40);
        check(!dac_bclk, "R6 clock low at strobe", dac_bclk, 0);
        if (rd_i == wr_i) begin
          check(1'b0, "R11 unexpected word", acc, 0);
        end else begin
          check(acc == exp_q[rd_i % 64], "R3 word", acc, exp_q[rd_i % 64]);
          rd_i++;
        end
        bit_cnt = 0;
        le_lo = 1;
      end else if (dac_latch_n && !p_le) begin
        check(le_lo == EXP_40, "R7 strobe width", le_lo, EXP_40);
        check(word_done == 1'b1, "R9 done at release", word_done, 1);
        le_hi = 1;
      end else if (dac_latch_n) begin
        le_hi++;
      end else begin
        le_lo++;
      end
      if (word_done && !(dac_latch_n && !p_le))
        check(1'b0, "R9 stray done", word_done, 0);
      if (word_done) done_cnt++;
      p_bclk = dac_bclk; p_le = dac_latch_n; p_sd = dac_sdata;
    end
  end

  task automatic send_word(input logic [WB-1:0] v);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v;
    exp_q[wr_i % 64] = v;
    wr_i++;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = ~v;
    check(smp_ready == 1'b0, "R2 ready drops after accept", smp_ready, 0);
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 20000 && done_cnt < target; i++) @(negedge clk);
    check(done_cnt == target, "R9 words completed", done_cnt, target);
  endtask

  task automatic t_reset();
    check(smp_ready == 1'b1, "R1 ready", smp_ready, 1);
    check(dac_bclk == 1'b0, "R1 bclk", dac_bclk, 0);
    check(dac_latch_n == 1'b1, "R1 latch", dac_latch_n, 1);
    check(word_done == 1'b0, "R1 done", word_done, 0);
    check(dac_sdata == 1'b0, "R1 data", dac_sdata, 0);
  endtask

  task automatic t_patterns();
    send_word(18'h2AAAA); wait_done(done_cnt + 1);
    send_word(18'h15555); wait_done(done_cnt + 1);
    send_word(18'h12345); wait_done(done_cnt + 1);
  endtask

  task automatic t_extremes();
    send_word(18'h20000); wait_done(done_cnt + 1);
    send_word(18'h1FFFF); wait_done(done_cnt + 1);
    send_word(18'h3FFFF); wait_done(done_cnt + 1);
    send_word(18'h00000); wait_done(done_cnt + 1);
  endtask

  task automatic t_back_to_back();
    int base;
    base = done_cnt;
    for (int k = 0; k < 4; k++) send_word(WB'(18'h0F0F1 + k * 18'h11111));
    wait_done(base + 4);
  endtask

  task automatic t_busy_valid();
    int base;
    base = done_cnt;
    send_word(18'h29C35);
    for (int i = 0; i < 30; i++) begin
      smp_valid = 1'b1;
      smp_data  = WB'(i * 18'h0321B);
      @(negedge clk);
      if (smp_ready) check(1'b0, "R2 ready while busy", smp_ready, 0);
    end
    smp_valid = 1'b0;
    wait_done(base + 1);
    repeat (300) @(negedge clk);
    check(done_cnt == base + 1, "R11 no extra word", done_cnt, base + 1);
    check(rd_i == wr_i, "R11 word count", rd_i, wr_i);
  endtask

  task automatic t_idle_hold();
    send_word(18'h00001);
    wait_done(done_cnt + 1);
    repeat (20) @(negedge clk);
    check(dac_bclk == 1'b0, "R10 bclk idle", dac_bclk, 0);
    check(dac_latch_n == 1'b1, "R10 latch idle", dac_latch_n, 1);
    check(dac_sdata == 1'b1, "R10 data holds LSB", dac_sdata, 1);
    check(smp_ready == 1'b1, "R10 ready idle", smp_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_extremes();
    t_back_to_back();
    t_busy_valid();
    t_idle_hold();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule